// File: doc/BRIEF.md
# Programmable Pin Input Debounce Filter

This block conditions one general-purpose input pin before its level reaches the pin status seen by the rest of the chip. The raw pad level is first brought into the system clock domain by a two-flop synchroniser. It then passes through a filter that runs on the system clock but measures time in ticks of a slow real-time clock. Those ticks arrive as a single-cycle enable.

The filter window is a 4-bit count multiplied by one of four unit sizes, so the longest window is 15 × 2048 ticks. A 2-bit mode field sets the style of filtering. The filter can be bypassed. It can require every change in either direction to be held for the full window. It can also let pulses of one polarity through at once while still debouncing the return edge. A zero count bypasses the filter whatever the mode is.

All configuration inputs are plain static levels, so the block has no handshake. A configuration change takes effect on the next clock. If the window shrinks while a count is running, the level is taken at once when the running count already meets the new window.

Top module: `pin_glitch_filter`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `pin_filt` is 0.
- R2: The raw pin passes through two synchroniser flops and then the output register. With no filtering, a level applied before clock edge e appears on `pin_filt` after edge e+2.
- R3: With `filt_mode` = 2'b00 (off), `pin_filt` follows the synchronised pin on every clock, whatever the count and unit settings are.
- R4: With `win_count` = 0, `pin_filt` follows the synchronised pin on every clock in every mode.
- R5: With `filt_mode` = 2'b01 (both directions), `pin_filt` takes a new level only after the synchronised pin has differed from it for W tick-enabled cycles. Here W = `win_count` × unit. A new level applied before edge e appears after edge e+1+W when the tick is high every cycle. A shorter pulse in either direction never reaches the output.
- R6: The unit is chosen by {`unit_big`, `unit_sub`}: 00 gives 2 ticks, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R7: The window count restarts from zero whenever the synchronised pin returns to the current output level before the window has expired.
- R8: The window count advances only on cycles where `rtc_tick` is 1. With `rtc_tick` held at 0, a debounced transition never completes.
- R9: With `filt_mode` = 2'b10 (keep low pulses), a falling transition reaches `pin_filt` on the next clock after synchronisation, with no window. A rising transition is debounced as in R5.
- R10: With `filt_mode` = 2'b11 (keep high pulses), a rising transition reaches `pin_filt` on the next clock after synchronisation, with no window. A falling transition is debounced as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_tick | input | 1 | One-cycle enable marking a real-time clock period |
| pin_raw | input | 1 | Asynchronous pad level |
| win_count | input | 4 | Window length in units; 0 disables filtering |
| unit_big | input | 1 | Upper unit-select bit |
| unit_sub | input | 1 | Lower unit-select bit |
| filt_mode | input | 2 | 00 off, 01 both directions, 10 keep low pulses, 11 keep high pulses |
| pin_filt | output | 1 | Filtered pin level |

## Verification
Two functions can act on the same clock edge. One is the window expiring on a tick. The other is the synchronised pin falling back to the output level, which restarts the count. A third case is an immediate edge in a one-sided mode that lands while a debounce of the opposite direction is still counting.

The bench provokes these cases in three ways. It sends pulses one cycle shorter than the window and broken pulses that return for a single cycle. It gates the tick to every third cycle so that expiry and restart meet on tick and non-tick cycles. It switches to a one-sided mode while a count is in flight.

Each case is judged by a behavioural reference model that is compared with `pin_filt` on every clock. Directed latency measurements back up the model by counting the clocks from a pin change to the output change.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  typedef enum logic [1:0] {
    FM_OFF       = 2'b00,
    FM_BOTH      = 2'b01,
    FM_KEEP_LOW  = 2'b10,
    FM_KEEP_HIGH = 2'b11
  } filt_mode_e;
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) st[0] <= 1'b0;
          else        st[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) st[i] <= 1'b0;
          else        st[i] <= st[i-1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/pgf_window.sv
module pgf_window #(
  parameter int CNT_W = 4,
  parameter int SH0   = 1,
  parameter int SH1   = 3,
  parameter int SH2   = 9,
  parameter int SH3   = 11,
  localparam int LEN_W = CNT_W + SH3
) (
  input  logic [CNT_W-1:0] count,
  input  logic             big,
  input  logic             sub,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] cnt_ext;

  assign cnt_ext = {{(LEN_W-CNT_W){1'b0}}, count};

  always_comb begin
    unique case ({big, sub})
      2'b00:   len = cnt_ext << SH0;
      2'b01:   len = cnt_ext << SH1;
      2'b10:   len = cnt_ext << SH2;
      default: len = cnt_ext << SH3;
    endcase
  end
endmodule

// File: rtl/pgf_core.sv
module pgf_core #(
  parameter int LEN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pin_s,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] len,
  output logic             pin_q
);
  import pgf_pkg::*;

  filt_mode_e       mode_e;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W:0]   cnt_inc;
  logic             bypass;
  logic             fast;

  assign mode_e  = filt_mode_e'(mode);
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign bypass  = (mode_e == FM_OFF) || (len == '0);
  assign fast    = ((mode_e == FM_KEEP_LOW)  && !pin_s) ||
                   ((mode_e == FM_KEEP_HIGH) &&  pin_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      cnt   <= '0;
    end else if (bypass) begin
      pin_q <= pin_s;
      cnt   <= '0;
    end else if (pin_s == pin_q) begin
      cnt   <= '0;
    end else if (fast) begin
      pin_q <= pin_s;
      cnt   <= '0;
    end else if (tick) begin
      if (cnt_inc >= {1'b0, len}) begin
        pin_q <= pin_s;
        cnt   <= '0;
      end else begin
        cnt   <= cnt_inc[LEN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int UNIT_SH0    = 1,
  parameter int UNIT_SH1    = 3,
  parameter int UNIT_SH2    = 9,
  parameter int UNIT_SH3    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_tick,
  input  logic             pin_raw,
  input  logic [CNT_W-1:0] win_count,
  input  logic             unit_big,
  input  logic             unit_sub,
  input  logic [1:0]       filt_mode,
  output logic             pin_filt
);
  localparam int LEN_W = CNT_W + UNIT_SH3;

  logic             pin_sync;
  logic [LEN_W-1:0] win_len;

  pgf_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_raw),
    .q    (pin_sync)
  );

  pgf_window #(
    .CNT_W(CNT_W), .SH0(UNIT_SH0), .SH1(UNIT_SH1),
    .SH2(UNIT_SH2), .SH3(UNIT_SH3)
  ) window_i (
    .count(win_count),
    .big  (unit_big),
    .sub  (unit_sub),
    .len  (win_len)
  );

  pgf_core #(.LEN_W(LEN_W)) core_i (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (rtc_tick),
    .pin_s(pin_sync),
    .mode (filt_mode),
    .len  (win_len),
    .pin_q(pin_filt)
  );
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rtc_tick,
  input logic             pin_sync,
  input logic             pin_filt,
  input logic [CNT_W-1:0] win_count,
  input logic [1:0]       filt_mode
);
  AST_OFF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_mode == 2'b00) |=> (pin_filt == $past(pin_sync))); // R3

  AST_ZERO_COUNT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_count == '0) |=> (pin_filt == $past(pin_sync))); // R4

  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_mode == 2'b01 && win_count != '0 && !rtc_tick) |=> $stable(pin_filt)); // R8

  AST_LOW_PULSE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_mode == 2'b10 && win_count != '0 && pin_filt && !pin_sync) |=> !pin_filt); // R9

  AST_LOW_MODE_RISE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_mode == 2'b10 && win_count != '0 && !pin_filt && !rtc_tick) |=> !pin_filt); // R9

  AST_HIGH_PULSE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_mode == 2'b11 && win_count != '0 && !pin_filt && pin_sync) |=> pin_filt); // R10

  AST_HIGH_MODE_FALL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_mode == 2'b11 && win_count != '0 && pin_filt && !rtc_tick) |=> pin_filt); // R10
endmodule

bind pin_glitch_filter pgf_checker #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .rtc_tick (rtc_tick),
  .pin_sync (pin_sync),
  .pin_filt (pin_filt),
  .win_count(win_count),
  .filt_mode(filt_mode)
);

// File: tb/pin_glitch_filter_tb_top.sv
`timescale 1ns/1ps
module pin_glitch_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rtc_tick = 1'b1;
  logic       pin_raw = 1'b0;
  logic [3:0] win_count = 4'd3;
  logic       unit_big = 1'b0;
  logic       unit_sub = 1'b0;
  logic [1:0] filt_mode = 2'b01;
  logic       pin_filt;

  int    checks = 0;
  int    errors = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  // reference model state
  bit mq0, mq1, mo, ms;
  int mc, mw, munit;

  always #10 clk = ~clk;

  pin_glitch_filter dut_i (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pin_raw(pin_raw),
    .win_count(win_count), .unit_big(unit_big), .unit_sub(unit_sub),
    .filt_mode(filt_mode), .pin_filt(pin_filt)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mq0 = 0; mq1 = 0; mo = 0; mc = 0;
    end else begin
      ms = mq1;
      case ({unit_big, unit_sub})
        2'b00: munit = 2;
        2'b01: munit = 8;
        2'b10: munit = 512;
        default: munit = 2048;
      endcase
      mw = int'(win_count) * munit;
      if (filt_mode == 2'b00 || mw == 0) begin
        mo = ms; mc = 0;
      end else if (ms == mo) begin
        mc = 0;
      end else if ((filt_mode == 2'b10 && !ms) || (filt_mode == 2'b11 && ms)) begin
        mo = ms; mc = 0;
      end else if (rtc_tick) begin
        mc = mc + 1;
        if (mc >= mw) begin
          mo = ms; mc = 0;
        end
      end
      mq1 = mq0;
      mq0 = pin_raw;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done)
      check(pin_filt === mo, phase, int'(pin_filt), int'(mo));
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input bit lvl, input int exp, input string tag);
    int n;
    phase = tag;
    @(negedge clk);
    pin_raw = lvl;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (pin_filt !== lvl && n < 5000);
    check(n == exp, tag, n, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    cycles(5);
    check(pin_filt === 1'b0, "R1", int'(pin_filt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pin_filt === 1'b0, "R1", int'(pin_filt), 0);
    cmp_on = 1'b1;

    // R2 / R3: mode off, latency is two sync flops plus the output register
    filt_mode = 2'b00; win_count = 4'd5;
    measure(1, 3, "R2");
    measure(0, 3, "R3");
    phase = "R3";
    for (int i = 0; i < 12; i++) begin
      pin_raw = (i % 3 == 1);
      @(negedge clk);
    end
    pin_raw = 0; cycles(4);

    // R4: zero count bypasses in every mode
    filt_mode = 2'b01; win_count = 4'd0;
    measure(1, 3, "R4");
    measure(0, 3, "R4");
    filt_mode = 2'b10;
    measure(1, 3, "R4");
    measure(0, 3, "R4");

    // R5: both directions, W = 3 * 2 = 6
    filt_mode = 2'b01; win_count = 4'd3; unit_big = 0; unit_sub = 0;
    measure(1, 8, "R5");
    measure(0, 8, "R5");
    phase = "R5";
    pin_raw = 1; cycles(5);
    pin_raw = 0; cycles(12);
    check(pin_filt === 1'b0, "R5", int'(pin_filt), 0);

    // R7: broken pulse restarts the window
    phase = "R7";
    pin_raw = 1; cycles(5);
    pin_raw = 0; cycles(1);
    pin_raw = 1; cycles(5);
    pin_raw = 0; cycles(12);
    check(pin_filt === 1'b0, "R7", int'(pin_filt), 0);

    // R6: unit sizes
    win_count = 4'd2; unit_big = 0; unit_sub = 1;
    measure(1, 18, "R6");
    win_count = 4'd1; unit_big = 1; unit_sub = 0;
    measure(0, 514, "R6");
    unit_big = 1; unit_sub = 1;
    measure(1, 2050, "R6");
    filt_mode = 2'b00;
    measure(0, 3, "R3");

    // R8: count only on ticks
    filt_mode = 2'b01; win_count = 4'd2; unit_big = 0; unit_sub = 0;
    phase = "R8";
    pin_raw = 1;
    for (int i = 0; i < 40; i++) begin
      rtc_tick = (i % 3 == 0);
      if (i == 25) pin_raw = 0;
      if (i == 29) pin_raw = 1;
      @(negedge clk);
    end
    pin_raw = 0;
    for (int i = 0; i < 40; i++) begin
      rtc_tick = (i % 3 == 0);
      @(negedge clk);
    end
    rtc_tick = 0;
    pin_raw = 1; cycles(20);
    check(pin_filt === 1'b0, "R8", int'(pin_filt), 0);
    rtc_tick = 1; cycles(10);
    check(pin_filt === 1'b1, "R8", int'(pin_filt), 1);

    // R9: keep low pulses, W = 6
    filt_mode = 2'b10; win_count = 4'd3;
    measure(0, 3, "R9");
    measure(1, 8, "R9");
    phase = "R9";
    @(negedge clk);
    pin_raw = 0; cycles(1);
    pin_raw = 1; cycles(2);
    check(pin_filt === 1'b0, "R9", int'(pin_filt), 0);
    cycles(10);
    // mode switch while a rise is being debounced
    pin_raw = 0; cycles(4);
    pin_raw = 1; cycles(4);
    filt_mode = 2'b11; cycles(6);

    // R10: keep high pulses
    pin_raw = 1; cycles(10);
    measure(0, 8, "R10");
    measure(1, 3, "R10");
    phase = "R10";
    @(negedge clk);
    pin_raw = 0; cycles(1);
    pin_raw = 1; cycles(12);
    check(pin_filt === 1'b1, "R10", int'(pin_filt), 1);
    pin_raw = 0; cycles(1);
    pin_raw = 1; cycles(8);

    finish_run();
  end
endmodule